// File: doc/BRIEF.md
# Staged-Commit IQ Upconverter

This block shifts one or more complex baseband sample streams in frequency. Each channel has its own phase accumulator that adds a 32-bit tuning word every clock. The top 16 bits of the accumulator, plus a 16-bit phase offset, choose one of eight points on the unit circle. Each incoming I/Q sample is multiplied by that complex value. The product is rounded and saturated, and the result is registered on the channel output.

Software sets up the block through a byte-wide register port. Tuning word and phase offset are written into staging registers. A single strobe write then copies the staged values of every channel into the working registers on the same edge, so several channels retune in step. Two configuration controls act on each accumulator:

- a persistent clear, which holds it at zero;
- a single-cycle clear, which empties it once and then drops out by itself.

A source selector lets the output carry either the upconverted product or a fixed test word. The registered output of every channel can be read back byte by byte.

Top module: `duc_core`

## Requirements
- R1: While `rst_n` is low the outputs read zero. Reset also clears the working tuning word, the working phase offset and the accumulator. On the first cycle after release, the output is therefore the input rotated by phase zero.
- R2: Channel c owns addresses 16*(c+1) to 16*(c+1)+15. Its offsets are:
  - 0: configuration;
  - 2 to 5: tuning word;
  - 6 and 7: phase offset;
  - 8 to 11: output readback;
  - 12 to 15: test word.
  Multi-byte fields take the most significant byte at the lowest offset. Writes to the tuning word or phase offset only stage the value and leave the output unchanged.
- R3: A write to address 1 copies the staged tuning word and phase offset of every channel into the working registers at once. The output reflects the new values one clock after that write edge.
- R4: While configuration bit 0 is set, the accumulator is held at zero. When it is cleared, the accumulator advances by the working tuning word every cycle.
- R5: Writing configuration bit 1 zeroes the accumulator exactly once, on the edge after the write. The accumulator then resumes advancing without a further write.
- R6: The rotation phase is accumulator bits 31:16 plus the working phase offset, modulo 2^16. Its top three bits pick octant k, with cosine and sine equal to round(32767*cos(k*pi/4)) and round(32767*sin(k*pi/4)).
- R7: Per quadrature, the result is (sum of the two signed 16x16 products + 2^14) shifted right arithmetically by 15. It is then saturated to the range -32768..32767. I' = I*cos - Q*sin, and Q' = I*sin + Q*cos.
- R8: Each channel's 32-bit input and output word carries I in bits 15:0 and Q in bits 31:16. The output register is loaded one clock after the input sample is presented.
- R9: Configuration bits 3:2 select the output source:
  - 0: the rotated product;
  - 1: the test word;
  - 2 or 3: all-zero.
  The selection applies from the clock after the configuration write.
- R10: Reading offsets 8 to 11 of a channel returns that channel's registered output, most significant byte at offset 8. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 7 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 7 | Byte read address |
| rd_data | output | 8 | Combinational read data |
| iq_in | input | 32*NCH | Input samples, channel c in bits 32c+31:32c |
| iq_out | output | 32*NCH | Registered output samples, same layout |

## Verification
An input sample shows up on the output one clock after it is applied. A strobe or configuration write changes the output on the clock after its own write edge. A released persistent clear lets the rotation advance one octant per cycle, starting two cycles after the release edge. A single-cycle clear brings the output back to octant zero on the second clock after its write. The bench drives every input on the falling edge and samples on the following falling edge, and it counts each of these offsets into its expected sequences. Expected products come from real-valued cosine and sine with the stated rounding and saturation, swept over all eight octants and over corner inputs on both channels at once.

// File: rtl/duc_pkg.sv
// Shared widths, register offsets and arithmetic helpers for the staged upconverter.
// Assumes 16-bit quadratures, a 32-bit tuning word and a 16-bit phase offset.
package duc_pkg;
    localparam int FTW_W   = 32;
    localparam int POW_W   = 16;
    localparam int SMP_W   = 16;
    localparam int ADDR_W  = 7;
    localparam int OCT_W   = 3;
    localparam int IQ_W    = 2 * SMP_W;
    localparam int ACC_W   = 2 * SMP_W + 1;
    localparam int FTW_NB  = FTW_W / 8;
    localparam int POW_NB  = POW_W / 8;
    localparam int IQ_NB   = IQ_W / 8;
    localparam int OFF_CFG = 0;
    localparam int OFF_FTW = 2;
    localparam int OFF_POW = 6;
    localparam int OFF_DAT = 8;
    localparam int OFF_TST = 12;
    localparam int STB_ADDR = 1;
    localparam int SMP_MAX = (1 << (SMP_W - 1)) - 1;
    localparam int DIAG    = int'((longint'(SMP_MAX) * 46341 + 32768) >>> 16);
    localparam int RND     = 1 << (SMP_W - 2);

    // Unit-circle point for an octant, returned as {sin, cos}.
    function automatic logic [IQ_W-1:0] rot_lut(input logic [OCT_W-1:0] oct);
        logic [SMP_W-1:0] f, d, z;
        f = SMP_W'(SMP_MAX);
        d = SMP_W'(DIAG);
        z = '0;
        case (oct)
            3'd0: rot_lut = {z, f};
            3'd1: rot_lut = {d, d};
            3'd2: rot_lut = {f, z};
            3'd3: rot_lut = {d, -d};
            3'd4: rot_lut = {z, -f};
            3'd5: rot_lut = {-d, -d};
            3'd6: rot_lut = {-f, z};
            default: rot_lut = {-d, d};
        endcase
    endfunction

    // Clamp a widened signed value into one quadrature.
    function automatic logic [SMP_W-1:0] sat_smp(input logic signed [ACC_W-1:0] v);
        if (v > $signed(ACC_W'(SMP_MAX)))
            sat_smp = SMP_W'(SMP_MAX);
        else if (v < $signed(ACC_W'(-SMP_MAX - 1)))
            sat_smp = SMP_W'(-SMP_MAX - 1);
        else
            sat_smp = v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/duc_regs.sv
// Per-channel register file: staged and working tuning word and phase offset,
// configuration bits, single-cycle clear flag and test word.
// Assumes the top decodes the shared strobe address and passes it as `strobe`.
module duc_regs
    import duc_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              strobe,
    output logic [FTW_W-1:0]  ftw_stg,
    output logic [FTW_W-1:0]  ftw_act,
    output logic [POW_W-1:0]  pow_act,
    output logic              cfg_hold,
    output logic [1:0]        cfg_sel,
    output logic              clr_once,
    output logic [IQ_W-1:0]   test_word
);
    logic [POW_W-1:0] pow_stg;
    logic             hit;
    logic [3:0]       off;

    assign hit = wr_en && (wr_addr[ADDR_W-1:4] == (ADDR_W-4)'(CH + 1));
    assign off = wr_addr[3:0];

    for (genvar b = 0; b < FTW_NB; b++) begin : g_ftw
        // Stage one tuning-word byte; highest byte sits at the lowest offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ftw_stg[8*b +: 8] <= '0;
            else if (hit && off == 4'(OFF_FTW + FTW_NB - 1 - b))
                ftw_stg[8*b +: 8] <= wr_data;
        end
    end

    for (genvar b = 0; b < POW_NB; b++) begin : g_pow
        // Stage one phase-offset byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pow_stg[8*b +: 8] <= '0;
            else if (hit && off == 4'(OFF_POW + POW_NB - 1 - b))
                pow_stg[8*b +: 8] <= wr_data;
        end
    end

    for (genvar b = 0; b < IQ_NB; b++) begin : g_tst
        // Load one test-word byte, applied directly without staging.
        always_ff @(posedge clk) begin
            if (!rst_n)
                test_word[8*b +: 8] <= '0;
            else if (hit && off == 4'(OFF_TST + IQ_NB - 1 - b))
                test_word[8*b +: 8] <= wr_data;
        end
    end

    // Configuration: persistent clear and source select; one-cycle clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_hold <= 1'b0;
            cfg_sel  <= 2'd0;
            clr_once <= 1'b0;
        end else begin
            clr_once <= hit && off == 4'(OFF_CFG) && wr_data[1];
            if (hit && off == 4'(OFF_CFG)) begin
                cfg_hold <= wr_data[0];
                cfg_sel  <= wr_data[3:2];
            end
        end
    end

    // Commit staged values into the working registers on the shared strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_act <= '0;
            pow_act <= '0;
        end else if (strobe) begin
            ftw_act <= ftw_stg;
            pow_act <= pow_stg;
        end
    end
endmodule

// File: rtl/duc_nco.sv
// Phase accumulator with hold and single-cycle clear, followed by an
// eight-point rotation lookup. Assumes the phase offset adds to the top accumulator bits.
module duc_nco
    import duc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FTW_W-1:0] ftw,
    input  logic [POW_W-1:0] pow,
    input  logic             clr_hold,
    input  logic             clr_once,
    output logic [FTW_W-1:0] acc,
    output logic [SMP_W-1:0] cos_o,
    output logic [SMP_W-1:0] sin_o
);
    logic [POW_W-1:0] phase;

    // Advance the accumulator, or zero it under either clear control.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_hold || clr_once)
            acc <= '0;
        else
            acc <= acc + ftw;
    end

    // Combine with the phase offset and look up the rotation point.
    always_comb begin
        phase = acc[FTW_W-1 -: POW_W] + pow;
        {sin_o, cos_o} = rot_lut(phase[POW_W-1 -: OCT_W]);
    end
endmodule

// File: rtl/duc_mixer.sv
// Complex multiply with round-half-up and saturation, then the output source
// mux and output register. Assumes I in the low half and Q in the high half.
module duc_mixer
    import duc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IQ_W-1:0]  iq_in,
    input  logic [SMP_W-1:0] cos_i,
    input  logic [SMP_W-1:0] sin_i,
    input  logic [1:0]       sel,
    input  logic [IQ_W-1:0]  test_word,
    output logic [IQ_W-1:0]  iq_out
);
    logic signed [SMP_W-1:0]   si, sq, sc, ss;
    logic signed [2*SMP_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [ACC_W-1:0]   re_sum, im_sum, re_rnd, im_rnd;

    // Form, round and scale both quadratures of the rotated sample.
    always_comb begin
        si = $signed(iq_in[SMP_W-1:0]);
        sq = $signed(iq_in[IQ_W-1:SMP_W]);
        sc = $signed(cos_i);
        ss = $signed(sin_i);
        p_ic = si * sc;
        p_qs = sq * ss;
        p_is = si * ss;
        p_qc = sq * sc;
        re_sum = ACC_W'(p_ic) - ACC_W'(p_qs);
        im_sum = ACC_W'(p_is) + ACC_W'(p_qc);
        re_rnd = (re_sum + ACC_W'(RND)) >>> (SMP_W - 1);
        im_rnd = (im_sum + ACC_W'(RND)) >>> (SMP_W - 1);
    end

    // Register the selected output source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            iq_out <= '0;
        else begin
            case (sel)
                2'd0:    iq_out <= {sat_smp(im_rnd), sat_smp(re_rnd)};
                2'd1:    iq_out <= test_word;
                default: iq_out <= '0;
            endcase
        end
    end
endmodule

// File: rtl/duc_core.sv
// Top of the staged-commit upconverter: NCH channels sharing one byte register
// port and one commit strobe, plus byte readback of each channel's output.
// Assumes single-byte accesses and one output sample per clock.
module duc_core
    import duc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_data,
    input  logic [NCH*IQ_W-1:0] iq_in,
    output logic [NCH*IQ_W-1:0] iq_out
);
    logic                   strobe;
    logic [NCH*FTW_W-1:0]   ftw_stg_all, ftw_act_all, acc_all;
    logic [NCH*POW_W-1:0]   pow_act_all;
    logic [NCH-1:0]         hold_all, once_all;
    logic [NCH*2-1:0]       sel_all;
    logic [NCH*IQ_W-1:0]    test_all;

    assign strobe = wr_en && (wr_addr == ADDR_W'(STB_ADDR));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SMP_W-1:0] cos_w, sin_w;

        duc_regs #(.CH(c)) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .strobe(strobe),
            .ftw_stg(ftw_stg_all[c*FTW_W +: FTW_W]),
            .ftw_act(ftw_act_all[c*FTW_W +: FTW_W]),
            .pow_act(pow_act_all[c*POW_W +: POW_W]),
            .cfg_hold(hold_all[c]), .cfg_sel(sel_all[2*c +: 2]),
            .clr_once(once_all[c]),
            .test_word(test_all[c*IQ_W +: IQ_W])
        );

        duc_nco u_nco (
            .clk(clk), .rst_n(rst_n),
            .ftw(ftw_act_all[c*FTW_W +: FTW_W]),
            .pow(pow_act_all[c*POW_W +: POW_W]),
            .clr_hold(hold_all[c]), .clr_once(once_all[c]),
            .acc(acc_all[c*FTW_W +: FTW_W]),
            .cos_o(cos_w), .sin_o(sin_w)
        );

        duc_mixer u_mix (
            .clk(clk), .rst_n(rst_n),
            .iq_in(iq_in[c*IQ_W +: IQ_W]),
            .cos_i(cos_w), .sin_i(sin_w),
            .sel(sel_all[2*c +: 2]),
            .test_word(test_all[c*IQ_W +: IQ_W]),
            .iq_out(iq_out[c*IQ_W +: IQ_W])
        );
    end

    // Byte readback of the registered outputs, high byte at the lowest offset.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < IQ_NB; b++) begin
                if (rd_addr[ADDR_W-1:4] == (ADDR_W-4)'(c + 1) &&
                    rd_addr[3:0] == 4'(OFF_DAT + IQ_NB - 1 - b))
                    rd_data = iq_out[c*IQ_W + 8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/duc_core_chk.sv
// Property checker for the staged upconverter, bound to every duc_core instance.
// Assumes the internal buses of duc_core are visible by name at bind time.
module duc_core_chk
    import duc_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                strobe,
    input logic [NCH*FTW_W-1:0] ftw_stg_all,
    input logic [NCH*FTW_W-1:0] ftw_act_all,
    input logic [NCH*FTW_W-1:0] acc_all,
    input logic [NCH*POW_W-1:0] pow_act_all,
    input logic [NCH-1:0]       hold_all,
    input logic [NCH-1:0]       once_all,
    input logic [NCH*2-1:0]     sel_all,
    input logic [NCH*IQ_W-1:0]  test_all,
    input logic [NCH*IQ_W-1:0]  iq_out
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> iq_out == '0);

    a_r3_strobe_copy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> ftw_act_all == $past(ftw_stg_all));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r2_act_held: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe |=> $stable(ftw_act_all[c*FTW_W +: FTW_W]) &&
                        $stable(pow_act_all[c*POW_W +: POW_W]));

        a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
            hold_all[c] |=> acc_all[c*FTW_W +: FTW_W] == '0);

        a_r5_once_zero: assert property (@(posedge clk) disable iff (!rst_n)
            once_all[c] |=> acc_all[c*FTW_W +: FTW_W] == '0);

        a_r9_test_pass: assert property (@(posedge clk) disable iff (!rst_n)
            sel_all[2*c +: 2] == 2'd1 |=>
                iq_out[c*IQ_W +: IQ_W] == $past(test_all[c*IQ_W +: IQ_W]));

        a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            sel_all[2*c + 1] |=> iq_out[c*IQ_W +: IQ_W] == '0);
    end
endmodule

bind duc_core duc_core_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .ftw_stg_all(ftw_stg_all), .ftw_act_all(ftw_act_all), .acc_all(acc_all),
    .pow_act_all(pow_act_all), .hold_all(hold_all), .once_all(once_all),
    .sel_all(sel_all), .test_all(test_all), .iq_out(iq_out)
);

// File: tb/test_duc_core.sv
module test_duc_core;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [6:0]        wr_addr;
    logic [7:0]        wr_data;
    logic [6:0]        rd_addr;
    logic [7:0]        rd_data;
    logic [NCH*32-1:0] iq_in;
    logic [NCH*32-1:0] iq_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duc_core #(.NCH(NCH)) i_duc_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .iq_in(iq_in), .iq_out(iq_out)
    );

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic logic [15:0] sat16(input longint v);
        if (v > 32767) return 16'h7fff;
        if (v < -32768) return 16'h8000;
        return 16'(v);
    endfunction

    // Expected rotated word {Q', I'} for octant k, per R6 and R7.
    function automatic logic [31:0] model(input int i, input int q, input int oct);
        real ang;
        int c, s;
        longint re, im;
        ang = (oct % 8) * 3.14159265358979 / 4.0;
        c = rnd(32767.0 * $cos(ang));
        s = rnd(32767.0 * $sin(ang));
        re = (longint'(i) * c - longint'(q) * s + 16384) >>> 15;
        im = (longint'(i) * s + longint'(q) * c + 16384) >>> 15;
        return {sat16(im), sat16(re)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = 7'(a);
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_multi(input int a, input logic [31:0] v, input int nb);
        for (int b = 0; b < nb; b++)
            wr(a + b, int'(v >> (8 * (nb - 1 - b))) & 8'hff);
    endtask

    task automatic set_iq(input int c, input int i, input int q);
        iq_in[c*32 +: 32] = {16'(q), 16'(i)};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ti[7] = '{20000, 0, 32767, -32768, -32768, 12345, 1};
        int tq[7] = '{0, 20000, 32767, -32768, 32767, -23456, -1};
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 7'h18;
        set_iq(0, 22136, 4660);
        set_iq(1, -1000, 3000);
        repeat (3) @(negedge clk);
        chk("R1 reset out ch0", iq_out[31:0], 32'h0);
        chk("R1 reset out ch1", iq_out[63:32], 32'h0);
        chk("R1 reset readback", {24'h0, rd_data}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 working regs zero ch0", iq_out[31:0], model(22136, 4660, 0));
        chk("R1 working regs zero ch1", iq_out[63:32], model(-1000, 3000, 0));

        // Hold both accumulators; sweep every octant and corner inputs (R6 R7 R8 R3).
        wr(8'h10, 1);
        wr(8'h20, 1);
        for (int oct = 0; oct < 8; oct++) begin
            wr_multi(8'h16, 32'(oct << 13), 2);
            wr_multi(8'h26, 32'(((7 - oct) << 13) | 16'h0fff), 2);
            wr(1, 0);
            for (int k = 0; k < 7; k++) begin
                set_iq(0, ti[k], tq[k]);
                set_iq(1, tq[k], ti[k]);
                @(negedge clk);
                chk("R7 rotate ch0", iq_out[31:0], model(ti[k], tq[k], oct));
                chk("R6 rotate ch1 shared strobe", iq_out[63:32], model(tq[k], ti[k], 7 - oct));
            end
        end

        // Staged phase has no effect until the strobe (R2, R3).
        set_iq(0, 20000, 0);
        wr_multi(8'h16, 32'h4000, 2);
        @(negedge clk);
        chk("R2 staged pow ignored", iq_out[31:0], model(20000, 0, 7));
        wr(1, 0);
        chk("R3 one cycle after strobe", iq_out[31:0], model(20000, 0, 7));
        @(negedge clk);
        chk("R3 strobe applied", iq_out[31:0], model(20000, 0, 2));

        // Persistent clear keeps phase fixed although the tuning word is nonzero (R4).
        wr_multi(8'h12, 32'h2000_0000, 4);
        wr_multi(8'h16, 32'h0, 2);
        wr(1, 0);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk("R4 hold keeps phase", iq_out[31:0], model(20000, 0, 0));
            @(negedge clk);
        end
        wr(8'h10, 0);
        for (int k = 1; k <= 10; k++) begin
            chk("R4 release advances", iq_out[31:0], model(20000, 0, (k >= 2) ? k - 2 : 0));
            @(negedge clk);
        end
        wr(8'h10, 2);
        chk("R5 before clear", iq_out[31:0], model(20000, 0, 2));
        @(negedge clk);
        chk("R5 last old phase", iq_out[31:0], model(20000, 0, 3));
        @(negedge clk);
        chk("R5 cleared once", iq_out[31:0], model(20000, 0, 0));
        @(negedge clk);
        chk("R5 resumes", iq_out[31:0], model(20000, 0, 1));
        @(negedge clk);
        chk("R5 resumes again", iq_out[31:0], model(20000, 0, 2));

        // Test word and reserved selections (R9), readback (R10).
        set_iq(1, -300, 700);
        wr_multi(8'h1c, 32'h89ab_cdef, 4);
        wr(8'h10, 5);
        chk("R9 select applies next cycle", iq_out[31:0] == 32'h89ab_cdef, 1'b0);
        @(negedge clk);
        chk("R9 test word", iq_out[31:0], 32'h89ab_cdef);
        for (int b = 0; b < 4; b++) begin
            rd_addr = 7'(8'h18 + b);
            #1;
            chk("R10 readback ch0", {24'h0, rd_data}, {24'h0, 8'(32'h89ab_cdef >> (8 * (3 - b)))});
        end
        for (int b = 0; b < 4; b++) begin
            rd_addr = 7'(8'h28 + b);
            #1;
            chk("R10 readback ch1", {24'h0, rd_data},
                {24'h0, 8'(model(-300, 700, 0) >> (8 * (3 - b)))});
        end
        rd_addr = 7'h14;
        #1;
        chk("R10 other address zero", {24'h0, rd_data}, 32'h0);
        @(negedge clk);
        wr(8'h10, 9);
        @(negedge clk);
        chk("R9 reserved 2", iq_out[31:0], 32'h0);
        wr(8'h10, 13);
        @(negedge clk);
        chk("R9 reserved 3", iq_out[31:0], 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule